// File: doc/BRIEF.md
# MII Management Frame Master

This block is the management-side master for an external Ethernet PHY. It generates the management clock (MDC) from the system clock and shifts complete read or write management frames over the bidirectional MDIO line without any per-bit help from software. A host uses three small registers to run an access. One register holds the start trigger, the operation, busy and a refusal flag. One holds the target register address and shows the PHY address. One holds write data and returns read data.

The PHY address does not come from software. It is captured once from a configuration-load strobe, which pulses after the nonvolatile configuration has been read. It then stays fixed for every later access. Address 1Fh is reserved. It is also the value after reset. A start aimed at it is refused at once: the refusal flag is set and the bus stays quiet. The pad is split into `mdio_o`, `mdio_oe` and `mdio_i`, so that the tristate buffer can live at the chip edge.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: MDC is held low whenever no frame is in progress. During a frame it has a period of 2*CLK_HALF system clocks and gives exactly 64 rising edges per frame.
- R2: A write frame is driven on every bit, MSB first, in this order: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 data bits.
- R3: A read frame uses opcode 10. The master drives the first 46 bits and releases MDIO (`mdio_oe`=0) for the last 18 bits. It samples the 16 data bits, MSB first, on MDC rising edges.
- R4: `mdio_o` changes only on an MDC falling edge or when a frame is loaded, never while MDC is high.
- R5: The register map is selected by `reg_addr`. In CTRL (0), a write uses bit0 as start and bit1 as the operation (1 read, 0 write); a read returns busy in bit0, the operation in bit1 and the refusal flag in bit2. In ADDR (1), bits [4:0] hold the register address and bits [12:8] show the PHY address as read-only. DATA is at 2. `reg_rdata` shows the selected register one clock after `reg_addr` is presented.
- R6: Busy reads as 1 from the clock after an accepted start and clears when the 64th bit completes.
- R7: During a frame the DATA register keeps its old value. Read data replaces it only at completion.
- R8: The PHY address is captured on the first `cfg_load` pulse, and later pulses are ignored.
- R9: After reset the PHY address is 1Fh and all outputs are 0. A start while the PHY address is 1Fh leaves busy at 0, sets the refusal flag, and produces no MDC edge and no `mdio_oe`. The flag clears on the next accepted start.
- R10: A CTRL write while busy is ignored: the frame in progress runs unchanged, no second frame follows, and the operation bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration-load strobe carrying the PHY address |
| cfg_phy_addr | input | 5 | PHY address presented with `cfg_load` |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The assertions take for granted that the host strobes `reg_wr` for only one clock, and that the PHY changes `mdio_i` only while MDC is low. They also assume the `cfg_load` pulse arrives with a settled address. The stimulus keeps within these limits: every host write is a one-cycle pulse launched away from the clock edge. The bench PHY model updates `mdio_i` only on MDC falling edges. Register and data values are drawn at random from a fixed seed. The PHY address is configured once, with a value other than 1Fh.

// File: rtl/phy_mgmt_pkg.sv
`timescale 1ns/1ps
package phy_mgmt_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam logic [PHY_AW-1:0] PHY_RESERVED = '1;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [1:0] START_SEQ = 2'b01;
  localparam logic [1:0] OPC_RD    = 2'b10;
  localparam logic [1:0] OPC_WR    = 2'b01;
  localparam logic [1:0] TA_WR     = 2'b10;
endpackage

// File: rtl/mdc_divider.sv
`timescale 1ns/1ps
module mdc_divider #(
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last   = (cnt == LAST);
  assign rise_tick = en & at_last & ~mdc;
  assign fall_tick = en & at_last & mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_seq.sv
`timescale 1ns/1ps
module mgmt_frame_seq
  import phy_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_rd,
  input  logic [PHY_AW-1:0] phy,
  input  logic [REG_AW-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 6 + PHY_AW + REG_AW + DATA_W;
  localparam int IW        = $clog2(FRAME_LEN);
  localparam int HDR_LEN   = FRAME_LEN - DATA_W - 2;
  localparam logic [IW-1:0] HDR_IDX  = IW'(HDR_LEN - 1);
  localparam logic [IW-1:0] DATA_IDX = IW'(FRAME_LEN - DATA_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] sh;
  logic [IW-1:0]        idx;
  logic                 rd_q;
  logic                 load;

  assign load  = start && !busy;
  assign frame = {{PRE_LEN{1'b1}}, START_SEQ, (op_rd ? OPC_RD : OPC_WR), phy, regad,
                  (op_rd ? 2'b11 : TA_WR), wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy    <= 1'b1;
        idx     <= '0;
        sh      <= frame << 1;
        rd_q    <= op_rd;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_tick && rd_q && idx >= DATA_IDX)
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= idx + 1'b1;
            mdio_o  <= sh[FRAME_LEN-1];
            sh      <= sh << 1;
            mdio_oe <= !rd_q || (idx < HDR_IDX);
          end
        end
      end
    end
  end

  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall_tick && !load) |=> $stable(mdio_o));

  // R3
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && idx > HDR_IDX) |-> !mdio_oe);
endmodule

// File: rtl/phy_mgmt_ctrl.sv
`timescale 1ns/1ps
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int CLK_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [PHY_AW-1:0] cfg_phy_addr,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [PHY_AW-1:0] phy_q;
  logic              cfg_seen;
  logic              op_rd_q;
  logic              err_q;
  logic [REG_AW-1:0] regad_q;
  logic [DATA_W-1:0] data_q;
  logic              busy, done, rise_tick, fall_tick;
  logic [DATA_W-1:0] seq_rdata;
  logic              ctrl_wr, accept, refuse, go;

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign accept  = ctrl_wr && reg_wdata[0] && !busy;
  assign refuse  = accept && (phy_q == PHY_RESERVED);
  assign go      = accept && !refuse;

  mdc_divider #(.CLK_HALF(CLK_HALF)) u_div (
    .clk(clk), .rst(rst), .en(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(go), .op_rd(reg_wdata[1]),
    .phy(phy_q), .regad(regad_q), .wdata(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rdata(seq_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q    <= PHY_RESERVED;
      cfg_seen <= 1'b0;
      op_rd_q  <= 1'b0;
      err_q    <= 1'b0;
      regad_q  <= '0;
      data_q   <= '0;
    end else begin
      if (cfg_load && !cfg_seen) begin
        phy_q    <= cfg_phy_addr;
        cfg_seen <= 1'b1;
      end
      if (ctrl_wr && !busy) begin
        op_rd_q <= reg_wdata[1];
        if (reg_wdata[0]) err_q <= refuse;
      end
      if (reg_wr && reg_addr == SEL_ADDR) regad_q <= reg_wdata[REG_AW-1:0];
      if (done && op_rd_q)                 data_q  <= seq_rdata;
      else if (reg_wr && reg_addr == SEL_DATA) data_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        SEL_CTRL: reg_rdata <= {{(DATA_W-3){1'b0}}, err_q, op_rd_q, busy};
        SEL_ADDR: reg_rdata <= DATA_W'({phy_q, 3'b000, regad_q});
        SEL_DATA: reg_rdata <= data_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R9
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (!busy && err_q));

  // R8
  phy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_seen |=> $stable(phy_q));

  // R1
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(reg_wr && reg_addr == SEL_DATA)) |=> ($stable(data_q) || $fell(busy)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> $stable(op_rd_q));
endmodule

// File: tb/phy_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module phy_mgmt_ctrl_tb;
  localparam int HALF = 4;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_phy_addr = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  phy_mgmt_ctrl #(.CLK_HALF(HALF), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_phy_addr(cfg_phy_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bus monitor
  int          rises = 0;
  logic [63:0] cap = '0, capoe = '0;
  time         t_first = 0, t_last = 0;
  logic [15:0] phy_val = '0;
  int          r4_viol = 0;
  int          oe_cycles = 0;
  logic        prev_mdc = 1'b0, prev_o = 1'b0;

  always @(posedge mdc) begin
    if (rises == 0) t_first = $time;
    t_last = $time;
    cap   = {cap[62:0], mdio_o};
    capoe = {capoe[62:0], mdio_oe};
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) mdio_i = phy_val[63-rises];
    else mdio_i = 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && mdc && prev_mdc && mdio_o !== prev_o) r4_viol++;
    if (mdio_oe) oe_cycles++;
    prev_mdc = mdc;
    prev_o = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic clear_mon();
    rises = 0; cap = '0; capoe = '0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      read_reg(2'd0, v);
      if (!v[0]) return;
    end
    chk(1'b0, "R6 busy never cleared", 64'(v), 64'h0);
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [63:0] exp_mask(bit rd);
    return rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
  endfunction

  logic [4:0]  phy_exp = 5'h1F;
  logic [15:0] data_shadow = '0;

  task automatic do_access(input bit rd, input logic [4:0] r, input logic [15:0] d, input logic [15:0] pv);
    logic [15:0] v;
    logic [63:0] m;
    phy_val = pv;
    write_reg(2'd1, {11'h0, r});
    if (!rd) begin
      write_reg(2'd2, d);
      data_shadow = d;
    end
    clear_mon();
    write_reg(2'd0, {14'h0, rd, 1'b1});
    read_reg(2'd0, v);
    chk(v[0] == 1'b1, "R6 busy after start", 64'(v), 64'h1);
    if (rd) begin
      read_reg(2'd2, v);
      chk(v == data_shadow, "R7 data held mid-frame", 64'(v), 64'(data_shadow));
    end
    wait_idle();
    chk(rises == 64, "R1 rising edges per frame", 64'(rises), 64'd64);
    chk((t_last - t_first) == 63 * 2 * HALF * CLK_NS, "R1 mdc period",
        64'(t_last - t_first), 64'(63 * 2 * HALF * CLK_NS));
    m = exp_mask(rd);
    chk(capoe == m, rd ? "R3 output enable pattern" : "R2 output enable pattern", capoe, m);
    chk((cap & m) == (exp_frame(rd, phy_exp, r, d) & m), rd ? "R3 read frame bits" : "R2 write frame bits",
        cap & m, exp_frame(rd, phy_exp, r, d) & m);
    if (rd) begin
      read_reg(2'd2, v);
      chk(v == pv, "R3 R7 read data captured", 64'(v), 64'(pv));
      data_shadow = pv;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h0);
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [4:0]  pa;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b0, "R9 outputs after reset",
        64'({mdc, mdio_oe, mdio_o}), 64'h0);
    read_reg(2'd0, v);
    chk(v == 16'h0, "R5 R9 CTRL after reset", 64'(v), 64'h0);
    read_reg(2'd1, v);
    chk(v[12:8] == 5'h1F, "R9 reserved PHY address after reset", 64'(v[12:8]), 64'h1F);

    // R9 refused start before configuration
    clear_mon();
    oe_cycles = 0;
    write_reg(2'd0, 16'h0001);
    read_reg(2'd0, v);
    chk(v[2:0] == 3'b100, "R9 refusal flag, no busy", 64'(v[2:0]), 64'h4);
    repeat (200) @(negedge clk);
    chk(rises == 0 && oe_cycles == 0, "R9 no bus activity on refusal",
        64'({rises[15:0], oe_cycles[15:0]}), 64'h0);

    // R8 first configuration load wins
    pa = 5'($urandom_range(0, 30));
    @(negedge clk); cfg_load = 1'b1; cfg_phy_addr = pa;
    @(negedge clk); cfg_load = 1'b0;
    phy_exp = pa;
    @(negedge clk); cfg_load = 1'b1; cfg_phy_addr = ~pa;
    @(negedge clk); cfg_load = 1'b0;
    read_reg(2'd1, v);
    chk(v[12:8] == pa, "R8 PHY address held from first load", 64'(v[12:8]), 64'(pa));

    // directed corners
    do_access(1'b0, 5'h1F, 16'hA5A5, 16'h0);
    read_reg(2'd0, v);
    chk(v[2] == 1'b0, "R9 refusal flag cleared by accepted start", 64'(v[2]), 64'h0);
    do_access(1'b1, 5'h00, 16'h0, 16'h8001);
    do_access(1'b0, 5'h00, 16'hFFFF, 16'h0);
    do_access(1'b1, 5'h15, 16'h0, 16'hFFFF);
    do_access(1'b1, 5'h0A, 16'h0, 16'h0000);

    // random accesses
    for (int i = 0; i < 8; i++) begin
      do_access(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                16'($urandom), 16'($urandom));
    end

    // R10 start while busy is ignored
    write_reg(2'd1, 16'h0007);
    write_reg(2'd2, 16'h3C5A);
    data_shadow = 16'h3C5A;
    clear_mon();
    write_reg(2'd0, 16'h0001);
    repeat (40) @(negedge clk);
    write_reg(2'd0, 16'h0003);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(rises == 64, "R10 no second frame", 64'(rises), 64'd64);
    chk(cap == exp_frame(1'b0, phy_exp, 5'h07, 16'h3C5A), "R10 frame unchanged",
        cap, exp_frame(1'b0, phy_exp, 5'h07, 16'h3C5A));
    read_reg(2'd0, v);
    chk(v[1] == 1'b0, "R10 operation bit unchanged", 64'(v[1]), 64'h0);
    read_reg(2'd2, v);
    chk(v == 16'h3C5A, "R7 write frame keeps DATA", 64'(v), 64'h3C5A);

    chk(r4_viol == 0, "R4 mdio_o stable while mdc high", 64'(r4_viol), 64'h0);
    summary();
  end
endmodule